// File: doc/BRIEF.md
# Password-Guarded GPIO Bank Registers

This block holds the configuration and output state of up to eight banks of 32 general-purpose lines behind a simple synchronous register bus. Each line has a control word whose bit 0 selects its direction. Each bank has an output latch that software changes through separate set and clear registers, and a read-only image of the pins taken through a two-flop synchronizer. The pin side receives an output vector, an output-enable vector and an input vector. Interrupt detection, debounce and pad control belong to other blocks.

A per-bank lock word protects the direction settings. When a line's lock bit is 1, writes to that line's control word are dropped without any error. The lock word can be changed only by the bus write that directly follows a write of the key value 0x00A5A501 to the key register. Any other write in between cancels the arming. After reset, every line is locked, configured as an input and driving low.

Word address map (byte offsets; b is the bank, n is the line = 32·b + bit): output latch 0x000+4b, synchronized input 0x020+4b, output set 0x040+4b, output clear 0x060+4b, control word 0x100+4n, lock word 0x500+4b, key register 0x520.

Top module: `gpio_lockbank_regs`

## Requirements
- R1: While reset is applied and just after it, pin_oe and pin_out are all 0, every lock word reads 0xFFFFFFFF, every control word reads 0x00000001 and every output latch reads 0.
- R2: The read data is combinational from the current address. The output latch reads back at 0x000+4b. The set, clear and key registers read as 0. An address with bits [1:0] not zero, or one outside the map, reads 0 and a write to it changes nothing.
- R3: A write to 0x040+4b sets the output latch bits of bank b where the data is 1 and leaves the other bits alone. It works whatever the lock state, and pin_out follows the latch one clock later. When no write occurs, pin_out holds.
- R4: A write to 0x060+4b clears the latch bits of bank b where the data is 1 and leaves the other bits alone.
- R5: Bit 0 of control word 0x100+4n stores the direction: 1 is input, 0 is output. pin_oe[n] is the inverse of that bit. Bits 31..1 read as 0, and pin_oe changes only after a bus write.
- R6: A write to lock word 0x500+4b is taken only if the previous bus write was 0x00A5A501 to 0x520. A 1 bit locks its line and a 0 bit unlocks it.
- R7: Every bus write other than a correct key write cancels the arming. This includes the lock write that uses it, a wrong key value and a write to any other address. A lock write with no arming leaves the lock word unchanged. Cycles with no write do not cancel the arming.
- R8: A control-word write to a line whose lock bit is 1 is ignored. The word reads back unchanged and pin_oe does not change.
- R9: Register 0x020+4b returns pin_in through two flops. A pin change made between clock edges is still hidden after the first rising edge and visible after the second.
- R10: A bank index of NUM_BANKS or above, and a line index of 32·NUM_BANKS or above, reads 0. Writes to them, including lock writes, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pin_in | input | 32·NUM_BANKS | Pin levels, asynchronous |
| pin_out | output | 32·NUM_BANKS | Output latch |
| pin_oe | output | 32·NUM_BANKS | Output enable, 1 where the line is an output |

## Verification
The hardest state to reach from the ports is a lock word actually changing. It needs a key write immediately followed by a lock write, and a random address stream almost never lines those two up. The random phase therefore treats the key write as a macro. Most of the time the macro issues a lock write right after the key, with all-ones, all-zeros or random data. Sometimes it puts an unrelated write or a wrong key in between. This spreads unlocked lines across the banks, so that control writes then land on both locked and unlocked lines. Directed cases cover a lock write that consumes the arming, out-of-range banks and the two-edge synchronizer delay.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
    localparam int MAX_BANKS      = 8;
    localparam int LINES_PER_BANK = 32;
    localparam int WORD_W         = 32;

    localparam logic [31:0] UNLOCK_KEY  = 32'h00A5_A501;
    localparam logic [9:0]  W_CTRL_BASE = 10'd64;
    localparam logic [9:0]  W_LOCK_BASE = 10'd320;
    localparam logic [9:0]  W_KEY       = 10'd328;

    typedef enum logic [2:0] {
        RGN_NONE, RGN_OUT, RGN_IN, RGN_SET, RGN_CLR, RGN_CTRL, RGN_LOCK, RGN_KEY
    } region_e;

    typedef struct packed {
        region_e    region;
        logic [2:0] bank;
        logic [7:0] line;
        logic       valid;
    } decode_t;
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_lock_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic [11:0] addr,
    output decode_t     dec
);
    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    logic [9:0] word;

    always_comb begin
        word       = addr[11:2];
        dec.region = RGN_NONE;
        dec.bank   = word[2:0];
        dec.line   = 8'(word - W_CTRL_BASE);
        dec.valid  = 1'b0;
        if (addr[1:0] == 2'b00) begin
            if (word < 10'd32) begin
                unique case (word[4:3])
                    2'd0: dec.region = RGN_OUT;
                    2'd1: dec.region = RGN_IN;
                    2'd2: dec.region = RGN_SET;
                    default: dec.region = RGN_CLR;
                endcase
                dec.valid = int'(dec.bank) < NUM_BANKS;
            end else if (word >= W_CTRL_BASE && word < W_LOCK_BASE) begin
                dec.region = RGN_CTRL;
                dec.valid  = int'(dec.line) < NUM_LINES;
            end else if (word >= W_LOCK_BASE && word < W_KEY) begin
                dec.region = RGN_LOCK;
                dec.valid  = int'(dec.bank) < NUM_BANKS;
            end else if (word == W_KEY) begin
                dec.region = RGN_KEY;
                dec.valid  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.meta = pin_async;
        sy_d.sync = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign pin_sync = sy_q.sync;
endmodule

// File: rtl/gpio_lock_guard.sv
module gpio_lock_guard
    import gpio_lock_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  decode_t              dec,
    input  logic [WORD_W-1:0]    wdata,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] lock_bits,
    output logic                 armed
);
    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    typedef struct packed {
        logic                 armed;
        logic [NUM_LINES-1:0] lock;
    } guard_t;

    guard_t gd_d, gd_q;

    always_comb begin
        gd_d = gd_q;
        if (wr_en) begin
            gd_d.armed = (dec.region == RGN_KEY) && (wdata == UNLOCK_KEY);
            if (dec.region == RGN_LOCK && dec.valid && gd_q.armed) begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (int'(dec.bank) == b)
                        gd_d.lock[b*LINES_PER_BANK +: LINES_PER_BANK] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gd_q.armed <= 1'b0;
            gd_q.lock  <= '1;
        end else begin
            gd_q <= gd_d;
        end
    end

    assign lock_bits = gd_q.lock;
    assign armed     = gd_q.armed;
endmodule

// File: rtl/gpio_lockbank_regs.sv
module gpio_lockbank_regs
    import gpio_lock_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [11:0]                         bus_addr,
    input  logic                                bus_we,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    input  logic [NUM_BANKS*LINES_PER_BANK-1:0] pin_in,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] pin_out,
    output logic [NUM_BANKS*LINES_PER_BANK-1:0] pin_oe
);
    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    typedef struct packed {
        logic [NUM_LINES-1:0] dir;
        logic [NUM_LINES-1:0] out;
    } line_state_t;

    decode_t              dec;
    logic [NUM_LINES-1:0] lock_q;
    logic                 armed;
    logic [NUM_LINES-1:0] in_sync;
    line_state_t          ls_d, ls_q;
    logic [31:0]          rdata;

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) i_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    gpio_lock_guard #(.NUM_BANKS(NUM_BANKS)) i_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .dec       (dec),
        .wdata     (bus_wdata),
        .lock_bits (lock_q),
        .armed     (armed)
    );

    gpio_in_sync #(.WIDTH(NUM_LINES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .pin_sync  (in_sync)
    );

    always_comb begin
        ls_d = ls_q;
        if (bus_we && dec.valid) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (int'(dec.bank) == b) begin
                    if (dec.region == RGN_SET)
                        ls_d.out[b*LINES_PER_BANK +: LINES_PER_BANK] =
                            ls_q.out[b*LINES_PER_BANK +: LINES_PER_BANK] | bus_wdata;
                    if (dec.region == RGN_CLR)
                        ls_d.out[b*LINES_PER_BANK +: LINES_PER_BANK] =
                            ls_q.out[b*LINES_PER_BANK +: LINES_PER_BANK] & ~bus_wdata;
                end
            end
            if (dec.region == RGN_CTRL) begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (int'(dec.line) == i && !lock_q[i])
                        ls_d.dir[i] = bus_wdata[0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_q.dir <= '1;
            ls_q.out <= '0;
        end else begin
            ls_q <= ls_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (dec.valid) begin
            unique case (dec.region)
                RGN_OUT, RGN_IN, RGN_LOCK: begin
                    for (int b = 0; b < NUM_BANKS; b++) begin
                        if (int'(dec.bank) == b) begin
                            if (dec.region == RGN_OUT)
                                rdata = ls_q.out[b*LINES_PER_BANK +: LINES_PER_BANK];
                            else if (dec.region == RGN_IN)
                                rdata = in_sync[b*LINES_PER_BANK +: LINES_PER_BANK];
                            else
                                rdata = lock_q[b*LINES_PER_BANK +: LINES_PER_BANK];
                        end
                    end
                end
                RGN_CTRL: begin
                    for (int i = 0; i < NUM_LINES; i++) begin
                        if (int'(dec.line) == i) rdata = {31'b0, ls_q.dir[i]};
                    end
                end
                default: rdata = '0;
            endcase
        end
    end

    assign bus_rdata = rdata;
    assign pin_out   = ls_q.out;
    assign pin_oe    = ~ls_q.dir;
endmodule

// File: rtl/gpio_lockbank_chk.sv
module gpio_lockbank_chk
    import gpio_lock_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic [11:0]                         bus_addr,
    input logic                                bus_we,
    input logic [31:0]                         bus_wdata,
    input logic [NUM_BANKS*LINES_PER_BANK-1:0] pin_out,
    input logic [NUM_BANKS*LINES_PER_BANK-1:0] pin_oe,
    input logic [NUM_BANKS*LINES_PER_BANK-1:0] lock_bits,
    input logic                                armed
);
    localparam int NUM_LINES = NUM_BANKS * LINES_PER_BANK;

    logic [9:0] w;
    logic [9:0] lw;
    logic       aligned, key_hit, lock_hit, ctrl_hit, locked_tgt;

    always_comb begin
        w          = bus_addr[11:2];
        lw         = w - 10'd64;
        aligned    = bus_addr[1:0] == 2'b00;
        key_hit    = aligned && w == 10'd328 && bus_wdata == 32'h00A5_A501;
        lock_hit   = aligned && int'(w) >= 320 && int'(w) < 320 + NUM_BANKS;
        ctrl_hit   = aligned && int'(w) >= 64 && int'(w) < 64 + NUM_LINES;
        locked_tgt = 1'b0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (int'(lw) == i) locked_tgt = lock_bits[i];
        end
    end

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && armed && lock_hit) |=> $stable(lock_bits));

    // R6
    key_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && key_hit) |=> armed);

    // R7
    write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !key_hit) |=> !armed);

    // R8
    locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ctrl_hit && locked_tgt) |=> $stable(pin_oe));

    // R3
    out_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_out));

    // R5
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_oe));
endmodule

bind gpio_lockbank_regs gpio_lockbank_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .lock_bits (lock_q),
    .armed     (armed)
);

// File: tb/test_gpio_lockbank_regs.sv
module test_gpio_lockbank_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int NL = NB * 32;
    localparam logic [31:0] KEY = 32'h00A5_A501;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;

    logic [NL-1:0] m_dir, m_out, m_lock;
    logic          m_armed;
    int            n_vec = 0;
    int            n_bad = 0;
    logic [31:0]   rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_lockbank_regs #(.NUM_BANKS(NB)) i_gpio_lockbank_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string tag, logic [NL-1:0] act, logic [NL-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_write(logic [11:0] a, logic [31:0] d);
        int w;
        w = int'(a[11:2]);
        if (a[1:0] == 2'b00) begin
            if (w >= 16 && w < 24 && w - 16 < NB) m_out[(w-16)*32 +: 32] |= d;
            if (w >= 24 && w < 32 && w - 24 < NB) m_out[(w-24)*32 +: 32] &= ~d;
            if (w >= 64 && w - 64 < NL && !m_lock[w-64]) m_dir[w-64] = d[0];
            if (w >= 320 && w - 320 < NB && m_armed) m_lock[(w-320)*32 +: 32] = d;
        end
        m_armed = (a[1:0] == 2'b00) && (w == 328) && (d == KEY);
    endtask

    function automatic logic [31:0] exp_read(logic [11:0] a);
        int w;
        w = int'(a[11:2]);
        if (a[1:0] != 2'b00) return '0;
        if (w < 8 && w < NB) return m_out[w*32 +: 32];
        if (w >= 8 && w < 16 && w - 8 < NB) return pin_in[(w-8)*32 +: 32];
        if (w >= 64 && w - 64 < NL) return {31'b0, m_dir[w-64]};
        if (w >= 320 && w - 320 < NB) return m_lock[(w-320)*32 +: 32];
        return '0;
    endfunction

    task automatic do_write(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic read_check(string tag, logic [11:0] a);
        logic [31:0] v;
        do_read(a, v);
        check(tag, NL'(v), NL'(exp_read(a)));
    endtask

    function automatic logic [11:0] rand_addr();
        int r, b, l;
        r = int'($urandom_range(0, 6));
        b = int'($urandom_range(0, 7));
        l = int'($urandom_range(0, 255));
        case (r)
            0: return 12'(4*b);
            1: return 12'(32 + 4*b);
            2: return 12'(64 + 4*b);
            3: return 12'(256 + 4*l);
            4: return 12'(1280 + 4*b);
            5: return 12'h520;
            default: return 12'(96 + 4*b);
        endcase
    endfunction

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        m_dir = '1; m_out = '0; m_lock = '1; m_armed = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pin_out", pin_out, '0);
        rst_n = 1'b1;
        read_check("R1 lock word", 12'h500);
        read_check("R1 ctrl word", 12'h100);
        read_check("R1 out latch", 12'h000);
        // R8 locked line ignores control write
        do_write(12'h100 + 12'd20, 32'h0);
        read_check("R8 ctrl locked", 12'h114);
        check("R8 oe locked", pin_oe, '0);
        // R6 unlock bank 0
        do_write(12'h520, KEY);
        do_write(12'h500, 32'h0);
        read_check("R6 lock after key", 12'h500);
        // R5 direction write to unlocked line
        do_write(12'h114, 32'hFFFF_FFFE);
        read_check("R5 ctrl readback", 12'h114);
        check("R5 oe", pin_oe, NL'(1) << 5);
        // R7 intervening write cancels
        do_write(12'h520, KEY);
        do_write(12'h044, 32'h1);
        do_write(12'h500, 32'hFFFF_FFFF);
        read_check("R7 intervening", 12'h500);
        // R7 wrong key
        do_write(12'h520, KEY ^ 32'h1);
        do_write(12'h500, 32'hFFFF_FFFF);
        read_check("R7 wrong key", 12'h500);
        // R7 arming consumed by one lock write
        do_write(12'h520, KEY);
        do_write(12'h500, 32'h1);
        do_write(12'h500, 32'h3);
        read_check("R7 consumed", 12'h500);
        // R3 set, independent of lock (bank 1 still locked)
        do_write(12'h040, 32'h0000_00F0);
        read_check("R3 set", 12'h000);
        read_check("R3 set locked bank", 12'h004);
        check("R3 pin_out", pin_out, m_out);
        // R4 clear
        do_write(12'h060, 32'h0000_0030);
        read_check("R4 clear", 12'h000);
        // R2 write-only and key registers read 0, misaligned reads 0
        read_check("R2 set reads 0", 12'h040);
        read_check("R2 key reads 0", 12'h520);
        read_check("R2 misaligned", 12'h001);
        // R9 two-flop synchronizer
        @(negedge clk);
        pin_in = {NL{1'b1}};
        @(negedge clk);
        #1 bus_addr = 12'h020;
        #1 check("R9 after one edge", NL'(bus_rdata), '0);
        @(negedge clk);
        #1 check("R9 after two edges", NL'(bus_rdata), NL'(32'hFFFF_FFFF));
        // R10 out-of-range bank and line
        do_write(12'h040 + 12'd20, 32'hFFFF_FFFF);
        check("R10 set ignored", pin_out, m_out);
        do_write(12'h520, KEY);
        do_write(12'h514, 32'h0);
        read_check("R10 lock bank5", 12'h514);
        read_check("R10 line 200", 12'h100 + 12'd800);
        // random phase
        pin_in = {$urandom, $urandom, $urandom, $urandom};
        for (int it = 0; it < 1500; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            if (op == 0) begin
                do_write(12'h520, ($urandom_range(0, 5) == 0) ? $urandom : KEY);
                if ($urandom_range(0, 4) == 0)
                    do_write(rand_addr(), $urandom);
                if ($urandom_range(0, 9) < 8) begin
                    int k;
                    k = int'($urandom_range(0, 2));
                    do_write(12'(1280 + 4*$urandom_range(0, 4)),
                             k == 0 ? 32'h0 : (k == 1 ? 32'hFFFF_FFFF : $urandom));
                end
            end else if (op <= 2) begin
                do_write(12'(256 + 4*$urandom_range(0, 140)), $urandom);
            end else begin
                do_write(rand_addr(), $urandom);
            end
            // R5 R8 direction vs lock, R3 R4 latch
            check("R5/R8 random oe", pin_oe, ~m_dir);
            check("R3/R4 random out", pin_out, m_out);
            read_check("R2 random read", rand_addr());
        end
        report();
        $finish;
    end
endmodule